// File: doc/BRIEF.md
# Trimmed Seconds Real-Time Clock with Alarm

This block keeps wall time as a count of seconds. A slow reference strobe, one pulse per cycle of a 32.768 kHz source brought into the system clock domain, drives a prescaler. The prescaler produces one seconds tick every divisor+1 strobes. A trim field in the same configuration word stretches one second in every 1024 by a programmed number of extra strobes, so a crystal that runs fast can be pulled back. The seconds tick advances a 32-bit counter that software may load. The tick is also compared against a 32-bit alarm value.

Two events, the seconds tick and the alarm match, each latch a pending flag. Each flag has its own enable bit. A flag is cleared by writing a one to its position. Each event drives its own interrupt line, which is the AND of its flag and its enable. Software reaches the four registers over a plain synchronous bus: a write lands on the rising clock edge and read data follows the address combinationally. The bus carries no streaming data, so it has no valid/ready handshake and cannot apply back-pressure. Every access completes in one cycle.

Register selects on `bus_addr_i`: 0 is the seconds counter, 1 is the alarm value, 2 is status/enable, 3 is the prescaler configuration.

Top module: `rtc_trim_alarm`

## Requirements
- R1: After reset, all four registers read zero and both interrupt outputs are low.
- R2: While the configuration register is zero, the prescaler behaves as if the divisor were 32767. The first tick comes on the 32768th reference strobe.
- R3: The configuration register keeps the divisor in bits [15:0] and the trim in bits [31:16]. A tick comes every divisor+1 strobes. Writing the configuration register restarts the prescaler and its 1024-second trim sequence.
- R4: The 1024th second after a configuration write, and every 1024th second after that, lasts divisor+1+trim strobes.
- R5: The seconds counter increments by one on each tick and can be written. A write in the same cycle as a tick wins, and the counter takes the written value.
- R6: Status bit 1, the seconds pending flag, is set on every tick whatever its enable bit holds.
- R7: Status bit 0, the alarm pending flag, is set on a tick that advances the counter to the alarm value.
- R8: Writing the status register clears each pending flag whose data bit is 1 and leaves flags whose data bit is 0 untouched.
- R9: If a flag's set event and its clear occur in the same cycle, the flag ends up set.
- R10: Status bits 2 and 3 are plain read/write enables for the alarm and seconds flags. Each enable sits two positions above its flag. `irq_alarm_o` is high exactly when bits 0 and 2 are both 1. `irq_sec_o` is high exactly when bits 1 and 3 are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_strobe_i | input | 1 | One-cycle pulse per 32.768 kHz reference period |
| bus_addr_i | input | 2 | Register select |
| bus_we_i | input | 1 | Write enable, write happens on the rising edge |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the selected register, combinational |
| irq_sec_o | output | 1 | Seconds interrupt: flag AND enable |
| irq_alarm_o | output | 1 | Alarm interrupt: flag AND enable |

## Verification
On every cycle the assertions check four things. The prescaler count stays within its current limit and wraps after each tick. The counter either advances by one or takes a written value. A set event always leaves its flag high, even when a clear lands in the same cycle. A write-one clears a flag and a write-zero keeps it. The scenarios cover what needs long stretches of stimulus: the fallback divisor when the configuration is zero, the exact strobe count of a trimmed second, the alarm matching on the right second, and the interrupt lines following each combination of flag and enable.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int DATA_W = 32;
  localparam int SEL_W  = 2;
  localparam int NUM_EV = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_COUNT  = 2'd0,
    SEL_ALARM  = 2'd1,
    SEL_STATUS = 2'd2,
    SEL_PRESC  = 2'd3
  } reg_sel_e;

  // event index: flag bit within status; enable sits NUM_EV higher
  localparam int EV_ALARM = 0;
  localparam int EV_SEC   = 1;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int CFG_W      = 32,
  parameter int DIV_W      = 16,
  parameter int DEF_DIV    = 32767,
  parameter int TRIM_SEC_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe_i,
  input  logic             cfg_wr_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic             sec_tick_o
);
  localparam int TRIM_W = CFG_W - DIV_W;
  localparam int LIM_W  = ((DIV_W > TRIM_W) ? DIV_W : TRIM_W) + 1;

  logic [CFG_W-1:0]      cfg_q;
  logic [LIM_W-1:0]      cnt_q;
  logic [TRIM_SEC_W-1:0] sec_seq_q;
  logic [DIV_W-1:0]      eff_div;
  logic [TRIM_W-1:0]     trim_val;
  logic                  trim_now;
  logic [LIM_W-1:0]      limit;

  always_comb begin
    eff_div  = (cfg_q == '0) ? DIV_W'(DEF_DIV) : cfg_q[DIV_W-1:0];
    trim_val = cfg_q[CFG_W-1:DIV_W];
    trim_now = &sec_seq_q;
    limit    = LIM_W'(eff_div) + (trim_now ? LIM_W'(trim_val) : '0);
  end

  assign sec_tick_o = strobe_i && !cfg_wr_i && (cnt_q >= limit);
  assign cfg_o      = cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      cnt_q     <= '0;
      sec_seq_q <= '0;
    end else if (cfg_wr_i) begin
      cfg_q     <= cfg_wdata_i;
      cnt_q     <= '0;
      sec_seq_q <= '0;
    end else if (strobe_i) begin
      if (cnt_q >= limit) begin
        cnt_q     <= '0;
        sec_seq_q <= sec_seq_q + 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assert_cnt_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= limit);

  assert_wrap_after_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick_o |=> (cnt_q == '0));
endmodule

// File: rtl/rtc_seconds.sv
module rtc_seconds #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         cnt_wr_i,
  input  logic         alm_wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] count_o,
  output logic [W-1:0] alarm_o,
  output logic         alarm_hit_o
);
  logic [W-1:0] count_q, alarm_q, count_nx;

  assign count_nx    = count_q + 1'b1;
  assign alarm_hit_o = tick_i && !cnt_wr_i && (count_nx == alarm_q);
  assign count_o     = count_q;
  assign alarm_o     = alarm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      alarm_q <= '0;
    end else begin
      if (cnt_wr_i)    count_q <= wdata_i;
      else if (tick_i) count_q <= count_nx;
      if (alm_wr_i)    alarm_q <= wdata_i;
    end
  end

  assert_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !cnt_wr_i) |=> (count_q == $past(count_q) + 1'b1));

  assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_i |=> (count_q == $past(wdata_i)));

  assert_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_hit_o && !alm_wr_i) |=> (count_q == alarm_q));
endmodule

// File: rtl/rtc_status.sv
module rtc_status #(
  parameter int NUM_EV = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_i,
  input  logic [2*NUM_EV-1:0] wdata_i,
  input  logic [NUM_EV-1:0]   set_i,
  output logic [2*NUM_EV-1:0] status_o,
  output logic [NUM_EV-1:0]   irq_o
);
  logic [NUM_EV-1:0] pend_q, en_q;

  for (genvar g = 0; g < NUM_EV; g++) begin : g_ev
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[g] <= 1'b0;
        en_q[g]   <= 1'b0;
      end else begin
        if (set_i[g])                  pend_q[g] <= 1'b1;
        else if (wr_i && wdata_i[g])   pend_q[g] <= 1'b0;
        if (wr_i)                      en_q[g]   <= wdata_i[NUM_EV+g];
      end
    end

    assign irq_o[g] = pend_q[g] & en_q[g];

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[g] |=> pend_q[g]);

    assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && wdata_i[g] && !set_i[g]) |=> !pend_q[g]);

    assert_w0_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !wdata_i[g] && pend_q[g]) |=> pend_q[g]);
  end

  assign status_o = {en_q, pend_q};
endmodule

// File: rtl/rtc_trim_alarm.sv
module rtc_trim_alarm (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ref_strobe_i,
  input  logic [1:0]  bus_addr_i,
  input  logic        bus_we_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  output logic        irq_sec_o,
  output logic        irq_alarm_o
);
  import rtc_pkg::*;

  localparam int ST_W = 2 * NUM_EV;

  reg_sel_e          sel;
  logic              wr_count, wr_alarm, wr_status, wr_presc;
  logic              sec_tick, alarm_hit;
  logic [DATA_W-1:0] count, alarm, presc_cfg;
  logic [ST_W-1:0]   status;
  logic [NUM_EV-1:0] ev_set, irq;

  assign sel       = reg_sel_e'(bus_addr_i);
  assign wr_count  = bus_we_i && (sel == SEL_COUNT);
  assign wr_alarm  = bus_we_i && (sel == SEL_ALARM);
  assign wr_status = bus_we_i && (sel == SEL_STATUS);
  assign wr_presc  = bus_we_i && (sel == SEL_PRESC);

  rtc_prescaler #(
    .CFG_W(DATA_W), .DIV_W(16), .DEF_DIV(32767), .TRIM_SEC_W(10)
  ) u_presc (
    .clk(clk), .rst_n(rst_n), .strobe_i(ref_strobe_i),
    .cfg_wr_i(wr_presc), .cfg_wdata_i(bus_wdata_i),
    .cfg_o(presc_cfg), .sec_tick_o(sec_tick)
  );

  rtc_seconds #(.W(DATA_W)) u_secs (
    .clk(clk), .rst_n(rst_n), .tick_i(sec_tick),
    .cnt_wr_i(wr_count), .alm_wr_i(wr_alarm), .wdata_i(bus_wdata_i),
    .count_o(count), .alarm_o(alarm), .alarm_hit_o(alarm_hit)
  );

  always_comb begin
    ev_set           = '0;
    ev_set[EV_ALARM] = alarm_hit;
    ev_set[EV_SEC]   = sec_tick;
  end

  rtc_status #(.NUM_EV(NUM_EV)) u_stat (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_status),
    .wdata_i(bus_wdata_i[ST_W-1:0]), .set_i(ev_set),
    .status_o(status), .irq_o(irq)
  );

  assign irq_alarm_o = irq[EV_ALARM];
  assign irq_sec_o   = irq[EV_SEC];

  always_comb begin
    unique case (sel)
      SEL_COUNT:  bus_rdata_o = count;
      SEL_ALARM:  bus_rdata_o = alarm;
      SEL_STATUS: bus_rdata_o = DATA_W'(status);
      default:    bus_rdata_o = presc_cfg;
    endcase
  end

  assert_irq_needs_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_sec_o || irq_alarm_o) |-> (status[1:0] != 2'b00));
endmodule

// File: tb/rtc_trim_alarm_test.sv
`timescale 1ns/1ps
module rtc_trim_alarm_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        strobe = 0;
  logic [1:0]  addr = 0;
  logic        we = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic        irq_sec, irq_alarm;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    int          req;
  } item_t;
  item_t sb_q[$];
  logic  mon_req = 0;

  always #2.5 clk = ~clk;

  rtc_trim_alarm uut (
    .clk(clk), .rst_n(rst_n), .ref_strobe_i(strobe),
    .bus_addr_i(addr), .bus_we_i(we), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_sec_o(irq_sec), .irq_alarm_o(irq_alarm)
  );

  // monitor: pops expected items, compares away from the active edge
  always @(negedge clk) begin
    if (mon_req && sb_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = sb_q.pop_front();
      act = it.is_irq ? {30'b0, irq_sec, irq_alarm} : rdata;
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL R%0d actual=0x%08h expected=0x%08h", it.req, act, it.exp);
      end
    end
  end

  task automatic rd_chk(input logic [1:0] a, input logic [31:0] e, input int r);
    @(posedge clk); #1;
    addr = a; we = 0; strobe = 0;
    sb_q.push_back('{1'b0, e, r});
    mon_req = 1;
    @(posedge clk); #1;
    mon_req = 0;
  endtask

  task automatic irq_chk(input logic [1:0] e, input int r);
    @(posedge clk); #1;
    sb_q.push_back('{1'b1, {30'b0, e}, r});
    mon_req = 1;
    @(posedge clk); #1;
    mon_req = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input bit t);
    @(posedge clk); #1;
    addr = a; wdata = d; we = 1; strobe = t;
    @(posedge clk); #1;
    we = 0; strobe = 0;
  endtask

  task automatic slow(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      strobe = 1;
    end
    @(posedge clk); #1;
    strobe = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    rd_chk(2'd0, 32'h0, 1);
    rd_chk(2'd1, 32'h0, 1);
    rd_chk(2'd2, 32'h0, 1);
    rd_chk(2'd3, 32'h0, 1);
    irq_chk(2'b00, 1);
    // R2 zero configuration falls back to 32768 strobes per second
    slow(32767);
    rd_chk(2'd0, 32'd0, 2);
    slow(1);
    rd_chk(2'd0, 32'd1, 2);
    // R6 seconds flag set with enables off, no interrupt
    rd_chk(2'd2, 32'h2, 6);
    irq_chk(2'b00, 6);
    // R3 divisor 3 -> 4 strobes, write restarts prescaler
    wr(2'd3, 32'd3, 0);
    rd_chk(2'd3, 32'd3, 3);
    slow(3);
    rd_chk(2'd0, 32'd1, 3);
    slow(1);
    rd_chk(2'd0, 32'd2, 3);
    // R5 load then advance
    wr(2'd0, 32'd100, 0);
    rd_chk(2'd0, 32'd100, 5);
    slow(4);
    rd_chk(2'd0, 32'd101, 5);
    // R8 write zero keeps, write one clears
    wr(2'd2, 32'h0, 0);
    rd_chk(2'd2, 32'h2, 8);
    wr(2'd2, 32'h2, 0);
    rd_chk(2'd2, 32'h0, 8);
    // R7 alarm
    wr(2'd1, 32'd103, 0);
    rd_chk(2'd1, 32'd103, 7);
    slow(4);
    rd_chk(2'd2, 32'h2, 7);
    wr(2'd2, 32'h2, 0);
    slow(4);
    rd_chk(2'd0, 32'd103, 7);
    rd_chk(2'd2, 32'h3, 7);
    irq_chk(2'b00, 7);
    // R10 enables and interrupt lines ({sec,alarm})
    wr(2'd2, 32'hC, 0);
    rd_chk(2'd2, 32'hF, 10);
    irq_chk(2'b11, 10);
    wr(2'd2, 32'h5, 0);
    rd_chk(2'd2, 32'h6, 10);
    irq_chk(2'b00, 10);
    wr(2'd2, 32'hE, 0);
    rd_chk(2'd2, 32'hC, 10);
    irq_chk(2'b00, 10);
    // R9 clear of seconds flag in the same cycle as a tick: set wins
    slow(3);
    wr(2'd2, 32'hE, 1);
    rd_chk(2'd2, 32'hE, 9);
    irq_chk(2'b10, 9);
    rd_chk(2'd0, 32'd104, 5);
    // R5 counter write wins over a tick
    slow(3);
    wr(2'd0, 32'd500, 1);
    rd_chk(2'd0, 32'd500, 5);
    slow(4);
    rd_chk(2'd0, 32'd501, 5);
    // R4 trim 5: the 1024th second takes 9 strobes
    wr(2'd0, 32'd0, 0);
    wr(2'd3, (32'd5 << 16) | 32'd3, 0);
    rd_chk(2'd3, 32'h0005_0003, 4);
    slow(4 * 1023);
    rd_chk(2'd0, 32'd1023, 4);
    slow(8);
    rd_chk(2'd0, 32'd1023, 4);
    slow(1);
    rd_chk(2'd0, 32'd1024, 4);
    slow(4);
    rd_chk(2'd0, 32'd1025, 4);

    repeat (2) @(posedge clk);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule